// File: doc/BRIEF.md
# Pipelined Synchronous SRAM With No Bus Turnaround

This block is a synthesizable behavioural model of a small pipelined synchronous static RAM whose read and write data both trail their command by two clock edges. Because the two latencies match, a host can place reads and writes back to back on one shared data bus with no idle cycle between them. The data bus is split into an input port, an output port and an output-enable that tells the host when the model is driving. The array is 256 words of 36 bits by default, split into four 9-bit byte lanes.

A command is taken at a rising edge when the clock-enable is asserted and the three chip selects are all active. A command either loads a new start address or continues a burst from an internal two-bit counter. The counter walks the four words of an aligned group in linear or interleaved order. An asynchronous output-enable can silence the bus at any time. A sleep input puts the whole model into a held state after two edges. On wake-up the model accepts no writes for two edges and flags any write that arrives in that window.

Top module: `nbt_sram`

## Requirements
- R1: After reset, `dq_oe` and `proto_err` are low and every array word reads back as zero.
- R2: A read accepted at edge N loads the output register at edge N+2. `dq_oe` is high for exactly the cycle after that edge. In every other cycle `dq_oe` is low, including the cycle in which a write's data is taken.
- R3: For a write accepted at edge N, `din` is captured at edge N+2. A read returns the effect of every write accepted before it, even one accepted a single edge earlier. Reads and writes may alternate on consecutive edges.
- R4: Byte enable `bw_n[i]` low writes bits [9i+8:9i] of the word. Bytes with `bw_n[i]` high keep their old value. A write with `bw_n` all high changes nothing.
- R5: A command is accepted only when `ce1_n` is low, `ce2` is high and `ce3_n` is low. Otherwise the edge is a deselect: no access, and no change to the burst counter.
- R6: While `cke_n` is high, edges have no effect. The pipeline, burst state, output register, `dout` and `proto_err` hold their values.
- R7: `adv` low loads a start address and the operation type (read when `we_n` is high). `adv` high issues the next burst access, with the same type as the burst's first access and the current `bw_n`. `adv` high before any burst has started since reset is a deselect.
- R8: With `burst_il` low, the k-th access of a burst uses address bits [1:0] equal to start+k modulo 4. With `burst_il` high it uses start XOR k. The upper address bits stay fixed, and the fifth access returns to the start address.
- R9: `oe_n` high forces `dq_oe` low at once, without waiting for a clock edge. It does not change any internal state.
- R10: Two accepted edges after `sleep` is seen high, the model is asleep. While asleep, commands are ignored, `dq_oe` is low, and the array and pipeline keep their contents. The model wakes two accepted edges after `sleep` is seen low.
- R11: For the two edges right after waking, a write command is discarded, reads and deselects proceed, and `proto_err` is high for the cycle after each discarded write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls everything |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write when low, read when high (on a start command) |
| adv | input | 1 | High continues the burst, low loads a start address |
| bw_n | input | 4 | Byte lane write enables, active low |
| addr | input | 8 | Word address |
| burst_il | input | 1 | Burst order: low linear, high interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| din | input | 36 | Write data, taken two edges after the write command |
| dout | output | 36 | Read data from the output register |
| dq_oe | output | 1 | High when the model drives read data onto the bus |
| proto_err | output | 1 | Pulses after a write discarded during wake-up |

## Verification
The assertions assume that `oe_n`, `sleep` and the chip selects are stable around the rising edge, and that sleep is entered only with no read still in flight. Otherwise an output register loaded before sleep could reappear on the bus after waking. The directed part of the stimulus lets the pipeline drain with deselect edges before raising `sleep`. It holds `sleep` low for the whole random phase. In both phases, inputs change only at the falling edge.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
    localparam int DEF_DEPTH  = 256;
    localparam int DEF_BYTES  = 4;
    localparam int DEF_BYTE_W = 9;
    localparam int BURST_W    = 2;
    localparam int WAKE_W     = 2;
    localparam logic [WAKE_W-1:0] WAKE_EDGES = 2'd2;
endpackage

// File: rtl/nbt_burst_gen.sv
module nbt_burst_gen #(
    parameter int CW = 2
) (
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] step,
    input  logic          interleave,
    output logic [CW-1:0] offs
);
    // linear order counts up from the start, interleaved order flips start bits
    always_comb begin
        if (interleave) offs = start ^ step;
        else            offs = start + step;
    end
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
    parameter int DEPTH  = 256,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = BYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BYTES-1:0] lane_en,
    input  logic [AW-1:0]    waddr,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rdata
);
    for (genvar l = 0; l < BYTES; l++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
            end else if (wr_en && lane_en[l]) begin
                lane_mem[waddr] <= wdata[l*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[l*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
    import nbt_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int BYTES  = DEF_BYTES,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = BYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             we_n,
    input  logic             adv,
    input  logic [BYTES-1:0] bw_n,
    input  logic [AW-1:0]    addr,
    input  logic             burst_il,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic             dq_oe,
    output logic             proto_err
);
    typedef struct packed {
        logic             v;
        logic             wr;
        logic [AW-1:0]    a;
        logic [BYTES-1:0] lanes;
    } stage_t;

    typedef struct packed {
        stage_t              s1;
        stage_t              s2;
        logic                bst_v;
        logic                bst_wr;
        logic [AW-1:0]       bst_base;
        logic [BURST_W-1:0]  bst_cnt;
        logic [W-1:0]        oreg;
        logic                oe;
        logic [1:0]          zz;
        logic [WAKE_W-1:0]   wake;
        logic                perr;
    } state_t;

    state_t              st_q, st_d;
    stage_t              cmd;
    logic                arr_we;
    logic [W-1:0]        arr_rdata;
    logic [BURST_W-1:0]  next_offs;
    logic                asleep;
    logic                waking;
    logic                selected;
    logic                s1_vld;
    logic                s2_rd;
    logic                oe_int;

    assign asleep   = st_q.zz[1];
    assign waking   = (st_q.wake != '0);
    assign selected = !ce1_n && ce2 && !ce3_n;
    assign s1_vld   = st_q.s1.v;
    assign s2_rd    = st_q.s2.v && !st_q.s2.wr;
    assign oe_int   = st_q.oe;

    nbt_burst_gen #(.CW(BURST_W)) u_bgen (
        .start      (st_q.bst_base[BURST_W-1:0]),
        .step       (st_q.bst_cnt + 1'b1),
        .interleave (burst_il),
        .offs       (next_offs)
    );

    nbt_array #(.DEPTH(DEPTH), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (arr_we),
        .lane_en (st_q.s2.lanes),
        .waddr   (st_q.s2.a),
        .wdata   (din),
        .raddr   (st_q.s2.a),
        .rdata   (arr_rdata)
    );

    always_comb begin
        st_d   = st_q;
        arr_we = 1'b0;
        cmd    = '0;
        if (!cke_n) begin
            st_d.perr = 1'b0;
            st_d.zz   = {st_q.zz[0], sleep};
            if (st_q.zz[1] && !st_q.zz[0]) st_d.wake = WAKE_EDGES;
            else if (waking)               st_d.wake = st_q.wake - 1'b1;

            if (!asleep) begin
                // completion stage: read into output register, write from din
                st_d.oe = s2_rd;
                if (s2_rd) st_d.oreg = arr_rdata;
                arr_we  = st_q.s2.v && st_q.s2.wr;
                st_d.s2 = st_q.s1;

                // command stage
                if (selected) begin
                    if (!adv) begin
                        cmd.v           = 1'b1;
                        cmd.wr          = !we_n;
                        cmd.a           = addr;
                        cmd.lanes       = ~bw_n;
                        st_d.bst_v      = 1'b1;
                        st_d.bst_wr     = !we_n;
                        st_d.bst_base   = addr;
                        st_d.bst_cnt    = '0;
                    end else if (st_q.bst_v) begin
                        cmd.v           = 1'b1;
                        cmd.wr          = st_q.bst_wr;
                        cmd.a           = {st_q.bst_base[AW-1:BURST_W], next_offs};
                        cmd.lanes       = ~bw_n;
                        st_d.bst_cnt    = st_q.bst_cnt + 1'b1;
                    end
                end
                if (cmd.v && cmd.wr && waking) begin
                    cmd.v     = 1'b0;
                    st_d.perr = 1'b1;
                    if (!adv) st_d.bst_v = 1'b0;
                end
                st_d.s1 = cmd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout      = st_q.oreg;
    assign dq_oe     = st_q.oe && !oe_n && !asleep;
    assign proto_err = st_q.perr;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cke_n,
    input logic         ce1_n,
    input logic         ce2,
    input logic         ce3_n,
    input logic         oe_n,
    input logic [W-1:0] dout,
    input logic         dq_oe,
    input logic         proto_err,
    input logic         asleep,
    input logic         waking,
    input logic         s1_vld,
    input logic         s2_rd,
    input logic         oe_int
);
    assert_oe_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !dq_oe);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout) && $stable(proto_err)));

    assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !asleep && (ce1_n || !ce2 || ce3_n)) |=> !s1_vld);

    assert_read_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !asleep && s2_rd) |=> oe_int);

    assert_err_in_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> ($past(waking) || $past(cke_n)));
endmodule

bind nbt_sram nbt_sram_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .oe_n      (oe_n),
    .dout      (dout),
    .dq_oe     (dq_oe),
    .proto_err (proto_err),
    .asleep    (asleep),
    .waking    (waking),
    .s1_vld    (s1_vld),
    .s2_rd     (s2_rd),
    .oe_int    (oe_int)
);

// File: tb/sim_nbt_sram.sv
module sim_nbt_sram;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cke_n, ce1_n, ce2, ce3_n, we_n, adv, burst_il, oe_n, sleep;
    logic [3:0]  bw_n;
    logic [7:0]  addr;
    logic [35:0] din;
    logic [35:0] dout;
    logic        dq_oe, proto_err;

    int    n_chk = 0;
    int    n_err = 0;
    string tag   = "R1";

    always #(CLK_P/2) clk = ~clk;

    nbt_sram u0 (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .we_n(we_n), .adv(adv), .bw_n(bw_n), .addr(addr),
        .burst_il(burst_il), .oe_n(oe_n), .sleep(sleep), .din(din),
        .dout(dout), .dq_oe(dq_oe), .proto_err(proto_err)
    );

    // reference model state
    logic [35:0] m_mem [256];
    logic        m_p1v, m_p1w, m_p2v, m_p2w;
    logic [7:0]  m_p1a, m_p2a;
    logic [3:0]  m_p1b, m_p2b;
    logic        m_bv, m_bw;
    logic [7:0]  m_bb;
    logic [1:0]  m_bc;
    logic [35:0] m_oreg;
    logic        m_oe, m_perr;
    logic [1:0]  m_zz;
    int          m_wake;

    function automatic logic [35:0] rnd36();
        return {$urandom(), $urandom()} & 64'hF_FFFF_FFFF;
    endfunction

    function automatic logic [1:0] burst_lo(logic [1:0] s, logic [1:0] k, logic il);
        return il ? (s ^ k) : (s + k);
    endfunction

    task automatic chk(string t, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        {m_p1v, m_p1w, m_p2v, m_p2w, m_bv, m_bw, m_oe, m_perr} = '0;
        m_p1a = 0; m_p2a = 0; m_p1b = 0; m_p2b = 0; m_bb = 0; m_bc = 0;
        m_oreg = '0; m_zz = 0; m_wake = 0;
    endtask

    task automatic model_edge();
        logic       nv, nw, perr;
        logic [7:0] na;
        logic [1:0] nzz;
        int         nwake;
        if (cke_n) return;
        perr  = 1'b0;
        nzz   = {m_zz[0], sleep};
        nwake = (m_zz[1] && !m_zz[0]) ? 2 : ((m_wake > 0) ? m_wake - 1 : 0);
        if (!m_zz[1]) begin
            m_oe = m_p2v && !m_p2w;
            if (m_oe) m_oreg = m_mem[m_p2a];
            if (m_p2v && m_p2w)
                for (int l = 0; l < 4; l++)
                    if (m_p2b[l]) m_mem[m_p2a][l*9 +: 9] = din[l*9 +: 9];
            m_p2v = m_p1v; m_p2w = m_p1w; m_p2a = m_p1a; m_p2b = m_p1b;
            nv = 1'b0; nw = 1'b0; na = '0;
            if (!ce1_n && ce2 && !ce3_n) begin
                if (!adv) begin
                    nv = 1'b1; nw = !we_n; na = addr;
                    m_bv = 1'b1; m_bw = !we_n; m_bb = addr; m_bc = 0;
                end else if (m_bv) begin
                    m_bc = m_bc + 1'b1;
                    nv = 1'b1; nw = m_bw;
                    na = {m_bb[7:2], burst_lo(m_bb[1:0], m_bc, burst_il)};
                end
            end
            if (nv && nw && m_wake > 0) begin
                nv = 1'b0; perr = 1'b1;
                if (!adv) m_bv = 1'b0;
            end
            m_p1v = nv; m_p1w = nw; m_p1a = na; m_p1b = ~bw_n;
        end
        m_perr = perr; m_zz = nzz; m_wake = nwake;
    endtask

    task automatic compare();
        logic exp_oe;
        exp_oe = m_oe && !oe_n && !m_zz[1];
        chk(tag, {35'd0, dq_oe}, {35'd0, exp_oe});
        if (exp_oe) chk(tag, dout, m_oreg);
        chk(tag, {35'd0, proto_err}, {35'd0, m_perr});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic cmd(logic w, logic a_adv, logic [7:0] a, logic [3:0] bwn);
        cke_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0;
        we_n = !w; adv = a_adv; addr = a; bw_n = bwn; din = rnd36();
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            cke_n = 0; ce1_n = 1; adv = 0; din = rnd36();
            tick();
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h2C41));
        rst_n = 0; cke_n = 1; ce1_n = 1; ce2 = 0; ce3_n = 1; we_n = 1; adv = 0;
        bw_n = 4'hF; addr = 0; burst_il = 0; oe_n = 0; sleep = 0; din = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, including zero array content
        tag = "R1";
        chk("R1", {34'd0, dq_oe, proto_err}, 36'd0);
        cmd(0, 0, 8'd77, 4'hF);
        idle(2);
        chk("R1", {35'd0, dq_oe}, 36'd1);
        chk("R1", dout, 36'd0);

        // R2 R3: alternating write/read with no gaps, read right after write
        tag = "R3";
        for (int i = 0; i < 6; i++) begin
            cmd(1, 0, 8'd10 + 8'(i), 4'h0);
            cmd(0, 0, 8'd10 + 8'(i), 4'hF);
        end
        tag = "R2";
        cmd(0, 0, 8'd10, 4'hF); cmd(1, 0, 8'd20, 4'h0); cmd(0, 0, 8'd20, 4'hF);
        idle(3);

        // R4: partial lanes and empty mask
        tag = "R4";
        cmd(1, 0, 8'd30, 4'h0);
        cmd(1, 0, 8'd30, 4'b1010);
        cmd(1, 0, 8'd30, 4'b0111);
        cmd(1, 0, 8'd30, 4'hF);
        cmd(0, 0, 8'd30, 4'hF);
        idle(3);

        // R5: each chip select inactive in turn
        tag = "R5";
        for (int k = 0; k < 3; k++) begin
            cke_n = 0; ce1_n = (k == 0); ce2 = (k != 1); ce3_n = (k == 2);
            we_n = 0; adv = 0; addr = 8'd40; bw_n = 4'h0; din = rnd36();
            tick();
        end
        cmd(0, 0, 8'd40, 4'hF);
        idle(3);

        // R6: stall in the middle of a read
        tag = "R6";
        cmd(0, 0, 8'd10, 4'hF);
        cke_n = 1; ce1_n = 0; we_n = 0; addr = 8'd10; repeat (3) begin din = rnd36(); tick(); end
        idle(3);
        cke_n = 1; repeat (2) tick();
        idle(1);

        // R7 R8: bursts in both orders, past the wrap
        tag = "R7";
        burst_il = 0;
        cmd(1, 0, 8'd50, 4'h0);
        for (int i = 0; i < 5; i++) cmd(0, 1, 8'd0, 4'h0);
        cmd(0, 0, 8'd51, 4'hF);
        for (int i = 0; i < 5; i++) cmd(1, 1, 8'd0, 4'hF);
        idle(3);
        tag = "R8";
        burst_il = 1;
        cmd(1, 0, 8'd62, 4'h0);
        for (int i = 0; i < 4; i++) cmd(0, 1, 8'd0, 4'h0);
        cmd(0, 0, 8'd61, 4'hF);
        for (int i = 0; i < 5; i++) cmd(0, 1, 8'd0, 4'hF);
        idle(3);
        burst_il = 0;

        // R9: asynchronous override mid-cycle
        tag = "R9";
        cmd(0, 0, 8'd50, 4'hF);
        idle(2);
        #1 oe_n = 1; #1;
        chk("R9", {35'd0, dq_oe}, 36'd0);
        oe_n = 0; #1;
        chk("R9", {35'd0, dq_oe}, 36'd1);
        idle(2);

        // R10: sleep with commands presented, then wake
        tag = "R10";
        sleep = 1;
        idle(2);
        cmd(1, 0, 8'd50, 4'h0);
        cmd(0, 0, 8'd50, 4'hF);
        cmd(0, 0, 8'd51, 4'hF);
        sleep = 0;
        idle(2);
        // R11: writes in the two wake edges are discarded
        tag = "R11";
        cmd(1, 0, 8'd70, 4'h0);
        cmd(1, 0, 8'd71, 4'h0);
        cmd(1, 0, 8'd72, 4'h0);
        cmd(0, 0, 8'd70, 4'hF);
        cmd(0, 0, 8'd71, 4'hF);
        cmd(0, 0, 8'd72, 4'hF);
        tag = "R10";
        cmd(0, 0, 8'd50, 4'hF);
        idle(3);

        // random mixed traffic, small address window for close reuse
        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            cke_n    = ($urandom() % 8) == 0;
            ce1_n    = ($urandom() % 10) == 0;
            ce2      = ($urandom() % 10) != 0;
            ce3_n    = ($urandom() % 10) == 0;
            we_n     = $urandom() % 2;
            adv      = ($urandom() % 3) == 0;
            bw_n     = 4'($urandom());
            addr     = 8'($urandom() % 16);
            burst_il = $urandom() % 2;
            oe_n     = ($urandom() % 10) == 0;
            din      = rnd36();
            tick();
        end
        oe_n = 0;
        idle(4);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule